// File: doc/BRIEF.md
# Synchronous Peripheral Bus Clock Bridge

This block lets a fast host with an asynchronous, strobe-based bus reach slow peripherals that run on a synchronous enable clock. It divides the host clock down to a free-running enable clock, `e_clk`. The period is ten host cycles by default: six cycles low, then four cycles high. When an external address decoder flags a slow-peripheral access, the block holds that access until the enable clock reaches a safe point in its low phase. The decoder raises the flag by driving `vpa_n` low while the host address strobe `as_n` is low.

At that point the block drives the active-low chip-select qualifier `vma_n`. The peripheral performs its transfer during the following high phase of `e_clk`. Read data is latched on the host clock edge at which `e_clk` falls. On that same edge `vma_n` is released, and a one-cycle completion pulse `cyc_done` tells the host that the cycle is over.

If the host keeps requesting straight after a completion, the next access runs in the very next enable period. If the host drops its address strobe in the middle of an access, the access ends at once, without a completion pulse and without a data capture.

Top module: `sync_bus_bridge`

## Requirements
In these requirements, "phase" means the number of host cycles elapsed since the last falling edge of `e_clk`, or since reset, and counts 0 to 9. A request is `as_n` = 0 and `vpa_n` = 0, as seen at a rising edge of `clk`.
- R1: `e_clk` is 0 in phases 0 to 5 and 1 in phases 6 to 9, and repeats every 10 host cycles without pause.
- R2: While `rst` is 1 at a clock edge, the phase returns to 0 (`e_clk` = 0, `vma_n` = 1, `cyc_done` = 0, `host_rdata` = 0). After release the first cycle is phase 0.
- R3: `vma_n` goes to 0 only after a request; `as_n` = 1 with `vpa_n` = 0, or `vpa_n` = 1 with `as_n` = 0, never asserts it.
- R4: A request seen in phase 0 to 4 asserts `vma_n` in the next cycle. A request seen in phase 5 to 9 asserts `vma_n` in the next phase 0. `vma_n` therefore falls only while `e_clk` is 0, at least one host cycle before `e_clk` rises.
- R5: Once asserted, `vma_n` stays 0 until the edge at which `e_clk` falls. On that edge `vma_n` returns to 1, `host_rdata` takes the value of `periph_rdata`, and `cyc_done` is 1 for exactly that one cycle.
- R6: When `as_n` is 1 at a clock edge, `vma_n` is 1 in the following cycle. An access ended this way gives no `cyc_done` and leaves `host_rdata` unchanged.
- R7: A request still present in the `cyc_done` cycle asserts `vma_n` again in the next cycle (phase 1), so consecutive accesses use consecutive enable periods.
- R8: `host_rdata` changes only on a capture edge; between captures it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Host address strobe, active low |
| vpa_n | input | 1 | Slow-peripheral access flag from the address decoder, active low |
| periph_rdata | input | DATA_W | Read data from the peripheral |
| e_clk | output | 1 | Free-running enable clock for the peripherals |
| vma_n | output | 1 | Valid-address qualifier for the peripheral chip select, active low |
| cyc_done | output | 1 | One-cycle completion pulse to the host |
| host_rdata | output | DATA_W | Latched read data |
| latch_stb | output | 1 | High in the cycle whose closing edge captures read data |

## Verification
The assertions assume that `as_n` and `vpa_n` are synchronous to `clk` and change only between edges. They also assume that `vpa_n` carries meaning only while `as_n` is low, and that a host ends or continues a cycle by the level of its strobe in the completion cycle.

The stimulus keeps within these assumptions. It drives every input on the falling edge of `clk`, and it releases the strobe in the same cycle that it sees `cyc_done`, except where it keeps the request asserted on purpose to ask for a back-to-back access. The stimulus places requests at each class of phase: early, late, the final low cycle, and the high phase. It also aborts an access and resets the block in the middle of an access.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_END  = 2'd2
  } xfer_state_t;

  // enable clock level for a given phase count
  function automatic logic phase_is_high(input int unsigned ph,
                                         input int unsigned low_len);
    return ph >= low_len;
  endfunction

  // a request may start at an edge leaving this phase when the new phase
  // is still low and at least one low cycle remains before the rise
  function automatic logic slot_open(input int unsigned ph,
                                     input int unsigned period,
                                     input int unsigned low_len);
    return (ph == period - 1) || (ph + 2 <= low_len);
  endfunction

  // phase that precedes the falling edge of the enable clock
  function automatic logic is_last_phase(input int unsigned ph,
                                         input int unsigned period);
    return ph == period - 1;
  endfunction

endpackage

// File: rtl/ebr_phase_gen.sv
module ebr_phase_gen
  import ebr_pkg::*;
#(
  parameter int unsigned PERIOD  = 10,
  parameter int unsigned LOW_LEN = 6,
  localparam int unsigned HIGH_LEN = PERIOD - LOW_LEN,
  localparam int unsigned PW = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst,
  output logic e_lvl,
  output logic fall_evt,
  output logic slot_ok
);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                               phase <= '0;
    else if (is_last_phase(32'(phase), PERIOD)) phase <= '0;
    else                                   phase <= phase + 1'b1;
  end

  assign e_lvl    = phase_is_high(32'(phase), LOW_LEN);
  assign fall_evt = is_last_phase(32'(phase), PERIOD);
  assign slot_ok  = slot_open(32'(phase), PERIOD, LOW_LEN);

  // independent run-length watcher for the enable clock shape
  logic        e_prev;
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_prev  <= 1'b0;
      run_len <= 0;
    end else begin
      e_prev <= e_lvl;
      if (e_lvl != e_prev) run_len <= 1;
      else                 run_len <= run_len + 1;
    end
  end

  a_r1_low_len : assert property (@(posedge clk) disable iff (rst)
    (e_lvl && !e_prev) |-> run_len == LOW_LEN);

  a_r1_high_len : assert property (@(posedge clk) disable iff (rst)
    (!e_lvl && e_prev) |-> run_len == HIGH_LEN);

  a_r2_restart_low : assert property (@(posedge clk)
    rst |=> !e_lvl);

endmodule

// File: rtl/ebr_cycle_ctl.sv
module ebr_cycle_ctl
  import ebr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic vpa_n,
  input  logic e_lvl,
  input  logic fall_evt,
  input  logic slot_ok,
  output logic vma_n,
  output logic done,
  output logic cap_stb
);

  xfer_state_t st, st_nx;
  logic        req;

  assign req = !as_n && !vpa_n;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (req && slot_ok) st_nx = ST_XFER;
      ST_XFER: begin
        if (as_n)          st_nx = ST_IDLE;
        else if (fall_evt) st_nx = ST_END;
      end
      ST_END:  st_nx = (req && slot_ok) ? ST_XFER : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign vma_n   = (st != ST_XFER);
  assign done    = (st == ST_END);
  assign cap_stb = (st == ST_XFER) && !as_n && fall_evt;

  a_r3_needs_req : assert property (@(posedge clk) disable iff (rst)
    $fell(vma_n) |-> $past(!as_n && !vpa_n));

  a_r4_start_in_low : assert property (@(posedge clk) disable iff (rst)
    $fell(vma_n) |-> !e_lvl);

  a_r5_done_on_fall : assert property (@(posedge clk) disable iff (rst)
    done |-> ($fell(e_lvl) && vma_n));

  a_r5_single_done : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_cap_then_done : assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> done);

  a_r6_strobe_release : assert property (@(posedge clk) disable iff (rst)
    as_n |=> vma_n);

  a_r7_back_to_back : assert property (@(posedge clk) disable iff (rst)
    (done && !as_n && !vpa_n) |=> !vma_n);

endmodule

// File: rtl/ebr_data_latch.sv
module ebr_data_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_stb,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (cap_stb) dout <= din;
  end

  a_r8_hold : assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(dout));

endmodule

// File: rtl/sync_bus_bridge.sv
module sync_bus_bridge #(
  parameter int unsigned DIV_RATIO  = 10,
  parameter int unsigned LOW_CYCLES = 6,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic              vpa_n,
  input  logic [DATA_W-1:0] periph_rdata,
  output logic              e_clk,
  output logic              vma_n,
  output logic              cyc_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              latch_stb
);

  logic fall_evt;
  logic slot_ok;
  logic cap_stb;

  ebr_phase_gen #(
    .PERIOD  (DIV_RATIO),
    .LOW_LEN (LOW_CYCLES)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .e_lvl    (e_clk),
    .fall_evt (fall_evt),
    .slot_ok  (slot_ok)
  );

  ebr_cycle_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .as_n     (as_n),
    .vpa_n    (vpa_n),
    .e_lvl    (e_clk),
    .fall_evt (fall_evt),
    .slot_ok  (slot_ok),
    .vma_n    (vma_n),
    .done     (cyc_done),
    .cap_stb  (cap_stb)
  );

  ebr_data_latch #(
    .DW (DATA_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .cap_stb (cap_stb),
    .din     (periph_rdata),
    .dout    (host_rdata)
  );

  assign latch_stb = cap_stb;

endmodule

// File: tb/test_sync_bus_bridge.sv
`timescale 1ns/1ps
module test_sync_bus_bridge;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       as_n = 1'b1;
  logic       vpa_n = 1'b1;
  logic [7:0] pdata = 8'h00;
  logic       e_clk, vma_n, done_o, latch_stb;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  sync_bus_bridge i_sync_bus_bridge (
    .clk          (clk),
    .rst          (rst),
    .as_n         (as_n),
    .vpa_n        (vpa_n),
    .periph_rdata (pdata),
    .e_clk        (e_clk),
    .vma_n        (vma_n),
    .cyc_done     (done_o),
    .host_rdata   (rd),
    .latch_stb    (latch_stb)
  );

  // start phase, cycles to vma_n low, cycles to cyc_done, read data
  localparam int V_PH [7]  = '{0, 2, 4, 5, 7, 8, 9};
  localparam int V_VL [7]  = '{1, 1, 1, 5, 3, 2, 1};
  localparam int V_DL [7]  = '{10, 8, 6, 15, 13, 12, 11};
  localparam int V_DAT [7] = '{8'h3C, 8'hA5, 8'h01, 8'hFE, 8'h5A, 8'h80, 8'h7F};

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  int  bph = 0;

  // expected phase, counted from reset per R1/R2
  always @(posedge clk) bph <= rst ? 0 : (bph == 9 ? 0 : bph + 1);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while (bph != p);
  endtask

  task automatic check_shape(input string tag);
    int bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (e_clk !== ((k % 10) >= 6)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic access(input int p, input logic [7:0] data, input int vl, input int dl);
    int gv = 0;
    int gd = 0;
    wait_phase(p);
    pdata = data; as_n = 1'b0; vpa_n = 1'b0;
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (gv == 0 && vma_n == 1'b0) gv = n;
      if (done_o) begin gd = n; break; end
    end
    chk(gv == vl, "R4 vma_n assert delay", gv, vl);
    chk(gd == dl, "R5 cyc_done delay", gd, dl);
    chk(rd == data, "R5 captured data", int'(rd), int'(data));
    chk(e_clk == 1'b0 && vma_n == 1'b1, "R5 e_clk low and vma_n released at done",
        int'({e_clk, vma_n}), 1);
    as_n = 1'b1; vpa_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R5 single-cycle done", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state, R2
    chk(vma_n == 1'b1, "R2 vma_n after reset", int'(vma_n), 1);
    chk(done_o == 1'b0, "R2 cyc_done after reset", int'(done_o), 0);
    chk(rd == 8'h00, "R2 host_rdata after reset", int'(rd), 0);
    check_shape("R1 enable clock 6 low 4 high");

    // vector table: R4, R5 across start phases
    for (int i = 0; i < 7; i++) access(V_PH[i], 8'(V_DAT[i]), V_VL[i], V_DL[i]);

    // R3: strobe without flag, flag without strobe
    begin
      int lows = 0;
      as_n = 1'b1; vpa_n = 1'b0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (!vma_n) lows++; end
      as_n = 1'b0; vpa_n = 1'b1;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (!vma_n) lows++; end
      as_n = 1'b1;
      chk(lows == 0, "R3 no vma_n without full request", lows, 0);
    end

    // R6 abort, R8 hold across abort
    begin
      int dones = 0;
      int moved = 0;
      wait_phase(1);
      pdata = 8'hC3; as_n = 1'b0; vpa_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(vma_n == 1'b0, "R6 vma_n low before abort", int'(vma_n), 0);
      as_n = 1'b1; vpa_n = 1'b1;
      @(negedge clk);
      chk(vma_n == 1'b1, "R6 vma_n released after strobe", int'(vma_n), 1);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done_o) dones++;
        if (rd != 8'h7F) moved++;
      end
      chk(dones == 0, "R6 no done after abort", dones, 0);
      chk(moved == 0, "R8 host_rdata held after abort", moved, 0);
    end

    // R7 back-to-back, R8 hold between captures
    begin
      int gap = 0;
      int moved = 0;
      wait_phase(3);
      pdata = 8'h11; as_n = 1'b0; vpa_n = 1'b0;
      do @(negedge clk); while (!done_o);
      chk(rd == 8'h11, "R7 first capture", int'(rd), 8'h11);
      pdata = 8'h22;
      @(negedge clk);
      gap = 1;
      chk(vma_n == 1'b0, "R7 vma_n reasserted next cycle", int'(vma_n), 0);
      while (!done_o && gap < 30) begin
        if (rd != 8'h11) moved++;
        @(negedge clk);
        gap++;
      end
      chk(gap == 10, "R7 second done one period later", gap, 10);
      chk(moved == 0, "R8 host_rdata held between captures", moved, 0);
      chk(rd == 8'h22, "R7 second capture", int'(rd), 8'h22);
      as_n = 1'b1; vpa_n = 1'b1;
      @(negedge clk);
    end

    // R2 mid-access reset
    wait_phase(2);
    as_n = 1'b0; vpa_n = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1; as_n = 1'b1; vpa_n = 1'b1;
    @(negedge clk);
    chk(vma_n == 1'b1 && done_o == 1'b0, "R2 reset ends access",
        int'({vma_n, done_o}), 2);
    rst = 1'b0;
    chk(rd == 8'h00, "R2 reset clears host_rdata", int'(rd), 0);
    check_shape("R2 enable clock restarts at phase 0");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule